// File: doc/BRIEF.md
# System Trap Indicator Word Generator

This block collects the trap conditions raised around the CPU and builds the 16-bit system trap indicator word. The conditions are a memory parity error, a privileged instruction violation, a memory-map protection key violation, a floating-point overflow or underflow, and an attempt to run an unimplemented extended opcode. When a trap fires, the block registers the word and raises a one-cycle request to write it into the reserved indicator location. In the next cycle it raises a one-cycle request to call through the vector location. It also latches the address of the faulting instruction, which the CPU loads into its location counter.

Word bits are numbered from 0 (most significant, vector index 15) to 15 (least significant, vector index 0). Each hardware condition owns one bit. Conditions that occur together merge into a single word. A trap with no hardware bit set means an unimplemented instruction. In that case the extended opcode field of the instruction is copied into the low field of the word. Three option-enable inputs mask the conditions of features that are not fitted. With all three cleared, only the unimplemented-instruction trap can occur.

Top module: `trap_indicator_gen`

## Requirements
- R1: While rst_ni is low, word_o, lc_o, wr_req_o and vec_req_o are all zero.
- R2: An enabled condition pulse sets its own word bit, using word bit numbering: parity is bit 3 (word_o[12]), privileged is bit 5 (word_o[10]), key is bit 6 (word_o[9]) and floating point is bit 7 (word_o[8]). The word is on word_o in the cycle after the pulse.
- R3: Conditions pulsed in the same cycle all set their bits in one word, and only one write request is raised.
- R4: An unimplemented trap with all four hardware bits clear copies instruction bits 7 to 12 (instr_i[8:3]) into word bits 10 to 15 (word_o[5:0]).
- R5: unimpl_i is ignored unless the major opcode, instruction bits 0 to 3 (instr_i[15:12]), is 0000. In that case there is no request, and word_o and lc_o keep their values.
- R6: par_en_i low masks the parity condition, map_en_i low masks the privileged and key conditions, and fp_en_i low masks the floating-point condition. A pulse that is only masked conditions raises no trap.
- R7: Word bits 0 to 2, 4, 8 and 9 (word_o[15:13], word_o[11], word_o[7:6]) are always zero. Word bits 10 to 15 are zero whenever any hardware bit is set.
- R8: wr_req_o is a one-cycle pulse in the cycle after a trap fires, and wr_addr_o equals IND_LOC. vec_req_o pulses in the cycle after wr_req_o, and vec_addr_o equals VEC_LOC.
- R9: lc_o captures instr_addr_i of the trapping cycle. word_o and lc_o hold until the next trap. Back-to-back traps each produce their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_err_i | input | 1 | Memory parity error pulse |
| priv_err_i | input | 1 | Privileged instruction violation pulse |
| key_err_i | input | 1 | Protection key violation pulse |
| fp_err_i | input | 1 | Floating-point over/underflow pulse |
| unimpl_i | input | 1 | Unimplemented extended opcode pulse |
| par_en_i | input | 1 | Parity option fitted |
| map_en_i | input | 1 | Memory-map option fitted |
| fp_en_i | input | 1 | Floating-point option fitted |
| instr_i | input | 16 | Instruction being executed |
| instr_addr_i | input | ADDR_W | Address of that instruction |
| word_o | output | 16 | Trap indicator word |
| lc_o | output | ADDR_W | Captured faulting address |
| wr_req_o | output | 1 | Request to write word_o to memory |
| wr_addr_o | output | ADDR_W | Indicator location |
| vec_req_o | output | 1 | Request to call through the vector |
| vec_addr_o | output | ADDR_W | Vector location |

## Verification
The bench builds the block with its defaults: a 16-bit address and the indicator and vector locations at 5 and 6. With these values the exact indicator and vector addresses can be checked, and lc_o carries a full-width address. The vector table sweeps every single condition and merged combinations. It also covers each enable mask, the major-opcode qualifier, and unimplemented traps with distinct extended fields. Directed tests then cover back-to-back traps, holding of the word and address across idle cycles, and a reset in the middle of the run.

// File: rtl/trap_ind_pkg.sv
package trap_ind_pkg;
  localparam int WORD_W = 16;
  localparam int N_HW   = 4;  // par, priv, key, fp
  // word bit numbers (0 = msb) of each hardware condition, index order par,priv,key,fp
  localparam int HW_POS [N_HW] = '{3, 5, 6, 7};
  localparam int OP_W   = 4;   // major opcode, instr bits 0..3
  localparam int EXT_LO = 7;   // extended opcode starts at instr bit 7
  localparam int EXT_W  = 6;
  localparam int FLD_LO = 10;  // copied into word bits 10..15

  function automatic int msb_idx(input int n);
    return WORD_W - 1 - n;
  endfunction

  localparam int OP_TOP  = WORD_W - 1;
  localparam int EXT_TOP = WORD_W - 1 - EXT_LO;
  localparam int FLD_TOP = WORD_W - 1 - FLD_LO;
endpackage

// File: rtl/trap_cond_mask.sv
module trap_cond_mask
  import trap_ind_pkg::*;
(
  input  logic [N_HW-1:0] hw_raw_i,
  input  logic [N_HW-1:0] hw_en_i,
  input  logic            unimpl_i,
  input  logic [OP_W-1:0] major_i,
  output logic [N_HW-1:0] hw_o,
  output logic            unimpl_o,
  output logic            fire_o
);
  assign hw_o     = hw_raw_i & hw_en_i;
  // extended-set instructions only carry major opcode zero
  assign unimpl_o = unimpl_i && (major_i == '0);
  assign fire_o   = (|hw_o) || unimpl_o;
endmodule

// File: rtl/trap_word_build.sv
module trap_word_build
  import trap_ind_pkg::*;
(
  input  logic [N_HW-1:0]   hw_i,
  input  logic              unimpl_i,
  input  logic [EXT_W-1:0]  ext_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    for (int k = 0; k < N_HW; k++) begin
      word_o[msb_idx(HW_POS[k])] = hw_i[k];
    end
    // field only meaningful when no hardware bit explains the trap
    if (unimpl_i && !(|hw_i)) begin
      word_o[FLD_TOP -: EXT_W] = ext_i;
    end
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_ind_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o,
  output logic [ADDR_W-1:0] lc_o,
  output logic              wr_req_o,
  output logic              vec_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o    <= '0;
      lc_o      <= '0;
      wr_req_o  <= 1'b0;
      vec_req_o <= 1'b0;
    end else begin
      wr_req_o  <= fire_i;
      vec_req_o <= wr_req_o;
      if (fire_i) begin
        word_o <= word_i;
        lc_o   <= addr_i;
      end
    end
  end

  a_r8_vec_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> vec_req_o);
  a_r8_vec_needs_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> $past(wr_req_o));
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_o |-> $stable(word_o) && $stable(lc_o));
endmodule

// File: rtl/trap_indicator_gen.sv
module trap_indicator_gen
  import trap_ind_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IND_LOC = 5,
  parameter int VEC_LOC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_err_i,
  input  logic              priv_err_i,
  input  logic              key_err_i,
  input  logic              fp_err_i,
  input  logic              unimpl_i,
  input  logic              par_en_i,
  input  logic              map_en_i,
  input  logic              fp_en_i,
  input  logic [15:0]       instr_i,
  input  logic [ADDR_W-1:0] instr_addr_i,
  output logic [15:0]       word_o,
  output logic [ADDR_W-1:0] lc_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              vec_req_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic [N_HW-1:0]   hw_raw, hw_en, hw_q;
  logic              unimpl_ok, fire;
  logic [WORD_W-1:0] word_d;
  logic [EXT_W-1:0]  ext_fld;
  logic              unused_instr_bits;

  assign hw_raw  = {fp_err_i, key_err_i, priv_err_i, par_err_i};
  assign hw_en   = {fp_en_i, map_en_i, map_en_i, par_en_i};
  assign ext_fld = instr_i[EXT_TOP -: EXT_W];
  assign unused_instr_bits = ^{instr_i[OP_TOP-OP_W:EXT_TOP+1], instr_i[EXT_TOP-EXT_W:0]};

  trap_cond_mask u_mask (
    .hw_raw_i (hw_raw),
    .hw_en_i  (hw_en),
    .unimpl_i (unimpl_i),
    .major_i  (instr_i[OP_TOP -: OP_W]),
    .hw_o     (hw_q),
    .unimpl_o (unimpl_ok),
    .fire_o   (fire)
  );

  trap_word_build u_build (
    .hw_i     (hw_q),
    .unimpl_i (unimpl_ok),
    .ext_i    (ext_fld),
    .word_o   (word_d)
  );

  trap_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .word_i    (word_d),
    .addr_i    (instr_addr_i),
    .word_o    (word_o),
    .lc_o      (lc_o),
    .wr_req_o  (wr_req_o),
    .vec_req_o (vec_req_o)
  );

  assign wr_addr_o  = ADDR_W'(IND_LOC);
  assign vec_addr_o = ADDR_W'(VEC_LOC);

  localparam int HW_MSK_IDX_PAR = WORD_W - 1 - 3;
  localparam int HW_MSK_IDX_FP  = WORD_W - 1 - 7;

  a_r7_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o[15:13] == 3'b000 && !word_o[11] && word_o[7:6] == 2'b00);
  a_r7_field_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && (word_o[12] || word_o[10:8] != 3'b000) |-> word_o[FLD_TOP:0] == '0);
  a_r4_field_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !word_o[12] && word_o[10:8] == 3'b000 |-> word_o[FLD_TOP:0] == $past(instr_i[EXT_TOP -: EXT_W]));
  a_r6_par_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !$past(par_en_i) |-> !word_o[HW_MSK_IDX_PAR]);
  a_r6_fp_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !$past(fp_en_i) |-> !word_o[HW_MSK_IDX_FP]);
  a_r9_lc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> lc_o == $past(instr_addr_i));
endmodule

// File: tb/trap_indicator_gen_tb.sv
`timescale 1ns/1ps
module trap_indicator_gen_tb;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic par_err_i = 0, priv_err_i = 0, key_err_i = 0, fp_err_i = 0, unimpl_i = 0;
  logic par_en_i = 1, map_en_i = 1, fp_en_i = 1;
  logic [15:0] instr_i = '0;
  logic [ADDR_W-1:0] instr_addr_i = '0;
  logic [15:0] word_o;
  logic [ADDR_W-1:0] lc_o, wr_addr_o, vec_addr_o;
  logic wr_req_o, vec_req_o;

  always #4 clk = ~clk;

  trap_indicator_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .par_err_i(par_err_i), .priv_err_i(priv_err_i), .key_err_i(key_err_i),
    .fp_err_i(fp_err_i), .unimpl_i(unimpl_i),
    .par_en_i(par_en_i), .map_en_i(map_en_i), .fp_en_i(fp_en_i),
    .instr_i(instr_i), .instr_addr_i(instr_addr_i),
    .word_o(word_o), .lc_o(lc_o), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
    .vec_req_o(vec_req_o), .vec_addr_o(vec_addr_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cond = {par,priv,key,fp,unimpl}, en = {par_en,map_en,fp_en}
  typedef struct packed {
    logic [4:0]  cond;
    logic [2:0]  en;
    logic [15:0] instr;
    logic        fire;
    logic [15:0] word;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{cond:5'b10000, en:3'b111, instr:16'h0000, fire:1'b1, word:16'h1000}, // R2 parity
    '{cond:5'b01000, en:3'b111, instr:16'h0000, fire:1'b1, word:16'h0400}, // R2 privileged
    '{cond:5'b00100, en:3'b111, instr:16'h0000, fire:1'b1, word:16'h0200}, // R2 key
    '{cond:5'b00010, en:3'b111, instr:16'h0000, fire:1'b1, word:16'h0100}, // R2 fp
    '{cond:5'b10110, en:3'b111, instr:16'h0000, fire:1'b1, word:16'h1300}, // R3 merge
    '{cond:5'b11110, en:3'b111, instr:16'h0FFF, fire:1'b1, word:16'h1700}, // R3 all four
    '{cond:5'b00001, en:3'b111, instr:16'h0FFF, fire:1'b1, word:16'h003F}, // R4 field
    '{cond:5'b00001, en:3'b111, instr:16'h0128, fire:1'b1, word:16'h0025}, // R4 field
    '{cond:5'b00001, en:3'b111, instr:16'h3FFF, fire:1'b0, word:16'h0000}, // R5 major nonzero
    '{cond:5'b10000, en:3'b011, instr:16'h0000, fire:1'b0, word:16'h0000}, // R6 par masked
    '{cond:5'b01100, en:3'b101, instr:16'h0000, fire:1'b0, word:16'h0000}, // R6 map masked
    '{cond:5'b10010, en:3'b110, instr:16'h0000, fire:1'b1, word:16'h1000}, // R6 fp masked
    '{cond:5'b00101, en:3'b111, instr:16'h0FFF, fire:1'b1, word:16'h0200}, // R7 field zero
    '{cond:5'b10011, en:3'b000, instr:16'h0FFF, fire:1'b1, word:16'h003F}  // R6 all masked
  };

  logic [15:0] exp_word = '0;
  logic [ADDR_W-1:0] exp_lc = '0;

  task automatic clear_in();
    {par_err_i, priv_err_i, key_err_i, fp_err_i, unimpl_i} = '0;
  endtask

  initial begin
    #1;
    chk("R1 word", word_o, 0);
    chk("R1 lc", lc_o, 0);
    chk("R1 wr_req", wr_req_o, 0);
    chk("R1 vec_req", vec_req_o, 0);
    chk("R8 wr_addr", wr_addr_o, 5);
    chk("R8 vec_addr", vec_addr_o, 6);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {par_err_i, priv_err_i, key_err_i, fp_err_i, unimpl_i} = TBL[i].cond;
      {par_en_i, map_en_i, fp_en_i} = TBL[i].en;
      instr_i = TBL[i].instr;
      instr_addr_i = 16'h0100 + 16'(i);
      @(negedge clk);
      clear_in();
      if (TBL[i].fire) begin
        exp_word = TBL[i].word;
        exp_lc = 16'h0100 + 16'(i);
      end
      chk($sformatf("R8 wr_req vec %0d", i), wr_req_o, TBL[i].fire);
      chk($sformatf("R2/R3/R4/R5/R6/R7 word vec %0d", i), word_o, exp_word);
      chk($sformatf("R9 lc vec %0d", i), lc_o, exp_lc);
      @(negedge clk);
      chk($sformatf("R8 vec_req vec %0d", i), vec_req_o, TBL[i].fire);
      chk($sformatf("R8 wr_req single vec %0d", i), wr_req_o, 0);
    end
    {par_en_i, map_en_i, fp_en_i} = 3'b111;

    // R9 back-to-back traps
    @(negedge clk);
    par_err_i = 1; instr_addr_i = 16'hA000;
    @(negedge clk);
    par_err_i = 0; fp_err_i = 1; instr_addr_i = 16'hB000;
    chk("R9 first word", word_o, 16'h1000);
    chk("R9 first lc", lc_o, 16'hA000);
    @(negedge clk);
    clear_in();
    chk("R9 second word", word_o, 16'h0100);
    chk("R9 second lc", lc_o, 16'hB000);
    chk("R3 second wr_req", wr_req_o, 1);
    chk("R8 vec after first", vec_req_o, 1);
    // R9 hold over idle cycles with changing inputs
    instr_addr_i = 16'hCCCC; instr_i = 16'h0FFF;
    repeat (4) @(negedge clk);
    chk("R9 hold word", word_o, 16'h0100);
    chk("R9 hold lc", lc_o, 16'hB000);
    chk("R8 idle vec_req", vec_req_o, 0);

    // R1 mid-run reset
    key_err_i = 1;
    @(negedge clk);
    clear_in();
    chk("R2 key before reset", word_o, 16'h0200);
    rst_ni = 0;
    #1;
    chk("R1 reset word", word_o, 0);
    chk("R1 reset lc", lc_o, 0);
    chk("R1 reset wr_req", wr_req_o, 0);
    chk("R1 reset vec_req", vec_req_o, 0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule